// File: doc/BRIEF.md
# Small-Page NAND Command Front End

This block is a synthesizable behavioural model of the command-decoding front end of a small-page NAND device, meant as a target when verifying a NAND controller. Each clock cycle with a write strobe is classified by the command-latch and address-latch inputs as a command byte, an address byte or a data byte. A read strobe returns a byte from the status register, the identification sequence or the page register, depending on the current mode. A ready/busy output drops for a configurable number of clocks after any operation that touches the array. A compact backing array of a few pages stands in for the cells.

Each 528-byte page is reached through one of three column windows: the lower half (0..255), the upper half (256..511) and the spare bytes (512..527). The pointer command chooses the window, and the column byte of the address is an offset inside it. The upper-half window lasts for one operation only. The spare window stays until another pointer command is written. Pages are grouped into blocks. A sequential read carries on across pages but stops at a block boundary.

Top module: `nand_cmd_if`

## Requirements
- R1: After reset, rb_o is 1 and io_o is 00h. Every array byte reads as FFh.
- R2: Writing 00h, 01h or 50h and then four address bytes (column, row, two more) starts a page load. rb_o is 0 for exactly T_READ cycles. Then io_o shows the byte at the start column, and each read strobe moves it to the next column.
- R3: 01h sets the start column to 256 plus the column byte. Once one read load or program confirm has used this window, the window returns to the lower half, where the start column is the column byte itself.
- R4: 50h sets the start column to 512 plus the low four bits of the column byte. This window stays in force across later operations until another pointer command arrives. A program in this window changes only columns 512..527.
- R5: Address bytes after the fourth are ignored, in both read and program sequences.
- R6: Program sequence: 80h, four address bytes, data bytes, then 10h. Each data byte goes to the next column. Data past column 527 is dropped. On 10h, each written byte is ANDed into the addressed page, unwritten bytes are left unchanged, and rb_o is 0 for exactly T_PROG cycles.
- R7: After 70h, every read strobe returns the status byte until another accepted command arrives. Bit 7 is 1, bit 6 is ready, bits 5..1 are 0. Bit 0 is 1 when the last program tried to turn a 0 bit into 1.
- R8: After 90h and one address byte, read strobes return ECh, 76h, A5h, C0h, and the sequence then repeats.
- R9: Erase sequence: 60h, three row address bytes, then D0h. The block holding the row (PAGES_PER_BLOCK pages) is set to FFh, the fail flag is cleared, and rb_o is 0 for exactly T_ERASE cycles.
- R10: A read strobe at column 527 loads the next page when that page is in the same block (T_READ busy cycles). The column restarts at 512 in the spare window and at 0 otherwise. On the last page of a block the read ends and io_o returns to 00h.
- R11: A command byte other than 00h, 01h, 50h, 80h, 10h, 60h, D0h, 70h, 90h and FFh is ignored and the current mode is kept.
- R12: While ce_ni is 1, all strobes are ignored and any sequential read ends, so io_o is 00h afterwards.
- R13: While busy, only 70h and FFh are accepted. With 70h, status bit 6 reads 0. FFh sets the block idle with the lower-half window, and rb_o is 0 for exactly T_RST cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low |
| cle_i | input | 1 | Marks a write cycle as a command byte |
| ale_i | input | 1 | Marks a write cycle as an address byte |
| we_i | input | 1 | One-cycle write strobe |
| re_i | input | 1 | One-cycle read strobe; moves on to the next output byte |
| io_i | input | 8 | Command, address or data byte |
| io_o | output | 8 | Byte that the next read strobe consumes |
| rb_o | output | 1 | 1 when ready, 0 when busy |

## Verification
Constrained-random programs use random windows, columns, rows and byte values. Because later programs often clear bits, both outcomes of the fail flag are exercised and checked against a bench model of the array. Random read-backs through a window different from the one used for programming separate pointer arithmetic errors from storage errors. Directed cases cover what random traffic rarely reaches: reading up to column 527 inside a block and on the last page of a block, spare programs that overrun the page, extra address bytes, commands written while busy or while chip enable is high, and an unsupported byte written in the middle of the identification sequence.

// File: rtl/nand_pkg.sv
package nand_pkg;
  localparam int PAGE_BYTES = 528;
  localparam int COL_W      = 10;
  localparam logic [COL_W-1:0] COL_LAST   = 10'd527;
  localparam logic [COL_W-1:0] SPARE_BASE = 10'd512;

  localparam logic [7:0] CMD_PTR_LO   = 8'h00;
  localparam logic [7:0] CMD_PTR_HI   = 8'h01;
  localparam logic [7:0] CMD_PTR_SP   = 8'h50;
  localparam logic [7:0] CMD_PROG     = 8'h80;
  localparam logic [7:0] CMD_PROG_GO  = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO = 8'hD0;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_ID       = 8'h90;
  localparam logic [7:0] CMD_RESET    = 8'hFF;

  typedef enum logic [2:0] {
    M_IDLE, M_READ_ADDR, M_READ_DATA, M_PROG_ADDR,
    M_PROG_DATA, M_ERASE_ADDR, M_STATUS, M_ID
  } mode_e;

  typedef enum logic [1:0] {R_LOW, R_HIGH, R_SPARE} window_e;

  function automatic logic [COL_W-1:0] col_of(window_e w, logic [7:0] b);
    case (w)
      R_HIGH:  return 10'd256 + {2'b00, b};
      R_SPARE: return SPARE_BASE + {6'd0, b[3:0]};
      default: return {2'b00, b};
    endcase
  endfunction

  function automatic logic [7:0] id_byte(logic [1:0] idx);
    case (idx)
      2'd0:    return 8'hEC;
      2'd1:    return 8'h76;
      2'd2:    return 8'hA5;
      default: return 8'hC0;
    endcase
  endfunction
endpackage

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  a_r13_busy_counts_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/nand_page_store.sv
module nand_page_store import nand_pkg::*; #(
  parameter int PAGES = 4,
  parameter int PPB   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic                     preset_i,
  input  logic                     commit_i,
  input  logic                     erase_i,
  input  logic [$clog2(PAGES)-1:0] row_i,
  input  logic                     wr_i,
  input  logic [COL_W-1:0]         col_i,
  input  logic [7:0]               wdata_i,
  input  logic [COL_W-1:0]         rcol_i,
  output logic [7:0]               rdata_o,
  output logic                     fail_o
);
  localparam int CELLS = PAGES * PAGE_BYTES;

  logic [7:0] mem_q  [CELLS];
  logic [7:0] page_q [PAGE_BYTES];
  logic       mask_q [PAGE_BYTES];
  logic       fail_q, bad;
  int         base, blk_base;

  assign base     = int'(row_i) * PAGE_BYTES;
  assign blk_base = (int'(row_i) / PPB) * PPB * PAGE_BYTES;

  // a written bit that would have to go from 0 to 1
  always_comb begin
    bad = 1'b0;
    for (int c = 0; c < PAGE_BYTES; c++)
      bad = bad | (mask_q[c] & (|(page_q[c] & ~mem_q[base + c])));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CELLS; i++) mem_q[i] <= 8'hFF;
    end else if (commit_i) begin
      for (int c = 0; c < PAGE_BYTES; c++)
        mem_q[base + c] <= mem_q[base + c] & page_q[c];
    end else if (erase_i) begin
      for (int i = 0; i < PPB * PAGE_BYTES; i++) mem_q[blk_base + i] <= 8'hFF;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < PAGE_BYTES; c++) begin
        page_q[c] <= 8'hFF;
        mask_q[c] <= 1'b0;
      end
    end else if (preset_i) begin
      for (int c = 0; c < PAGE_BYTES; c++) begin
        page_q[c] <= 8'hFF;
        mask_q[c] <= 1'b0;
      end
    end else if (load_i) begin
      for (int c = 0; c < PAGE_BYTES; c++) begin
        page_q[c] <= mem_q[base + c];
        mask_q[c] <= 1'b0;
      end
    end else if (wr_i && col_i <= COL_LAST) begin
      page_q[col_i] <= wdata_i;
      mask_q[col_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fail_q <= 1'b0;
    else if (commit_i) fail_q <= bad;
    else if (erase_i)  fail_q <= 1'b0;
  end

  assign rdata_o = (rcol_i <= COL_LAST) ? page_q[rcol_i] : 8'h00;
  assign fail_o  = fail_q;

  a_r7_fail_from_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> $past(commit_i));
  a_r6_single_array_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_i && erase_i));
endmodule

// File: rtl/nand_cmd_if.sv
module nand_cmd_if import nand_pkg::*; #(
  parameter int PAGES_PER_BLOCK = 2,
  parameter int BLOCKS          = 2,
  parameter int T_READ          = 3,
  parameter int T_PROG          = 5,
  parameter int T_ERASE         = 7,
  parameter int T_RST           = 2,
  parameter int CNT_W           = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_ni,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       we_i,
  input  logic       re_i,
  input  logic [7:0] io_i,
  output logic [7:0] io_o,
  output logic       rb_o
);
  localparam int PAGES = PAGES_PER_BLOCK * BLOCKS;
  localparam int ROW_W = $clog2(PAGES);

  mode_e            mode_q, mode_d;
  window_e          win_q, win_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [ROW_W-1:0] row_q, row_d, prow;
  logic [2:0]       acnt_q, acnt_d;
  logic [1:0]       id_q, id_d;
  logic             ld, pre, wr, cm, er, tgo, busy, fail;
  logic [CNT_W-1:0] tlen;
  logic [7:0]       rdata;
  logic             cmd_w, addr_w, data_w, rd_w, last_in_blk;

  assign cmd_w  = !ce_ni && we_i && cle_i && !ale_i;
  assign addr_w = !ce_ni && we_i && ale_i && !cle_i;
  assign data_w = !ce_ni && we_i && !ale_i && !cle_i;
  assign rd_w   = !ce_ni && re_i && !we_i;
  assign last_in_blk = (int'(row_q) % PAGES_PER_BLOCK) == PAGES_PER_BLOCK - 1;

  always_comb begin
    mode_d = mode_q; win_d = win_q; col_d = col_q; row_d = row_q;
    acnt_d = acnt_q; id_d = id_q; prow = row_q;
    ld = 1'b0; pre = 1'b0; wr = 1'b0; cm = 1'b0; er = 1'b0; tgo = 1'b0; tlen = '0;
    if (ce_ni) begin
      if (mode_q == M_READ_DATA) mode_d = M_IDLE;
    end else if (cmd_w) begin
      if (io_i == CMD_RESET) begin
        mode_d = M_IDLE; win_d = R_LOW; tgo = 1'b1; tlen = CNT_W'(T_RST);
      end else if (io_i == CMD_STATUS) begin
        mode_d = M_STATUS;
      end else if (!busy) begin
        case (io_i)
          CMD_PTR_LO: begin win_d = R_LOW;   mode_d = M_READ_ADDR; acnt_d = '0; end
          CMD_PTR_HI: begin win_d = R_HIGH;  mode_d = M_READ_ADDR; acnt_d = '0; end
          CMD_PTR_SP: begin win_d = R_SPARE; mode_d = M_READ_ADDR; acnt_d = '0; end
          CMD_PROG:   begin mode_d = M_PROG_ADDR; acnt_d = '0; pre = 1'b1; end
          CMD_PROG_GO:
            if ((mode_q == M_PROG_ADDR && acnt_q == 3'd4) || mode_q == M_PROG_DATA) begin
              cm = 1'b1; tgo = 1'b1; tlen = CNT_W'(T_PROG); mode_d = M_IDLE;
              if (win_q == R_HIGH) win_d = R_LOW;
            end
          CMD_ERASE:  begin mode_d = M_ERASE_ADDR; acnt_d = '0; end
          CMD_ERASE_GO:
            if (mode_q == M_ERASE_ADDR && acnt_q >= 3'd3) begin
              er = 1'b1; tgo = 1'b1; tlen = CNT_W'(T_ERASE); mode_d = M_IDLE;
            end
          CMD_ID:     begin mode_d = M_ID; id_d = '0; end
          default: ;
        endcase
      end
    end else if (addr_w && !busy) begin
      if (acnt_q != 3'd4) acnt_d = acnt_q + 3'd1;
      case (mode_q)
        M_READ_ADDR, M_PROG_ADDR: begin
          if (acnt_q == 3'd0) col_d = col_of(win_q, io_i);
          if (acnt_q == 3'd1) row_d = io_i[ROW_W-1:0];
          if (mode_q == M_READ_ADDR && acnt_q == 3'd3) begin
            ld = 1'b1; tgo = 1'b1; tlen = CNT_W'(T_READ); mode_d = M_READ_DATA;
            if (win_q == R_HIGH) win_d = R_LOW;
          end
        end
        M_ERASE_ADDR: if (acnt_q == 3'd0) row_d = io_i[ROW_W-1:0];
        default: ;
      endcase
    end else if (data_w && !busy) begin
      if ((mode_q == M_PROG_ADDR && acnt_q == 3'd4) || mode_q == M_PROG_DATA) begin
        mode_d = M_PROG_DATA;
        if (col_q <= COL_LAST) begin
          wr = 1'b1; col_d = col_q + 1'b1;
        end
      end
    end else if (rd_w && !busy) begin
      if (mode_q == M_READ_DATA) begin
        if (col_q == COL_LAST) begin
          if (last_in_blk) mode_d = M_IDLE;
          else begin
            row_d = row_q + 1'b1; prow = row_q + 1'b1;
            ld = 1'b1; tgo = 1'b1; tlen = CNT_W'(T_READ);
            col_d = (win_q == R_SPARE) ? SPARE_BASE : '0;
          end
        end else col_d = col_q + 1'b1;
      end else if (mode_q == M_ID) id_d = id_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_IDLE; win_q <= R_LOW; col_q <= '0; row_q <= '0;
      acnt_q <= '0; id_q <= '0;
    end else begin
      mode_q <= mode_d; win_q <= win_d; col_q <= col_d; row_q <= row_d;
      acnt_q <= acnt_d; id_q <= id_d;
    end
  end

  nand_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .start_i(tgo), .len_i(tlen), .busy_o(busy)
  );

  nand_page_store #(.PAGES(PAGES), .PPB(PAGES_PER_BLOCK)) u_store (
    .clk_i, .rst_ni, .load_i(ld), .preset_i(pre), .commit_i(cm), .erase_i(er),
    .row_i(prow), .wr_i(wr), .col_i(col_q), .wdata_i(io_i), .rcol_i(col_q),
    .rdata_o(rdata), .fail_o(fail)
  );

  always_comb begin
    case (mode_q)
      M_STATUS:    io_o = {1'b1, !busy, 5'b00000, fail};
      M_ID:        io_o = id_byte(id_q);
      M_READ_DATA: io_o = busy ? 8'h00 : rdata;
      default:     io_o = 8'h00;
    endcase
  end
  assign rb_o = !busy;

  a_r10_col_in_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_READ_DATA) |-> (col_q <= COL_LAST));
  a_r3_high_window_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_READ_DATA) |-> (win_q != R_HIGH));
  a_r4_spare_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_READ_DATA && win_q == R_SPARE) |-> (col_q >= SPARE_BASE));
  a_r13_busy_holds_column: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && rd_w) |=> $stable(col_q));
endmodule

// File: tb/tb_nand_cmd_if.sv
module tb_nand_cmd_if;
  localparam int T_READ = 3, T_PROG = 5, T_ERASE = 7, T_RST = 2;
  localparam int PPB = 2, BLOCKS = 2, PAGES = PPB * BLOCKS, PB = 528;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ce_n, cle, ale, we, re, rb;
  logic [7:0] din, dout;

  nand_cmd_if #(.PAGES_PER_BLOCK(PPB), .BLOCKS(BLOCKS), .T_READ(T_READ),
    .T_PROG(T_PROG), .T_ERASE(T_ERASE), .T_RST(T_RST)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .cle_i(cle), .ale_i(ale),
    .we_i(we), .re_i(re), .io_i(din), .io_o(dout), .rb_o(rb));

  int n_chk = 0, n_fail = 0;
  logic [7:0] mdl [PAGES*PB];
  int win_m = 0;
  logic fail_m = 1'b0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the strobe
  task automatic strobe(logic c, logic a, logic w, logic r, logic [7:0] d);
    cle = c; ale = a; we = w; re = r; din = d;
    @(negedge clk);
    cle = 0; ale = 0; we = 0; re = 0; din = 0;
  endtask
  task automatic cmd(logic [7:0] d);  strobe(1, 0, 1, 0, d); endtask
  task automatic adr(logic [7:0] d);  strobe(0, 1, 1, 0, d); endtask
  task automatic dat(logic [7:0] d);  strobe(0, 0, 1, 0, d); endtask
  task automatic rpulse();            strobe(0, 0, 0, 1, 8'h00); endtask

  task automatic wait_ready(int exp, string req);
    int n = 0;
    while (rb == 1'b0 && n < 1000) begin n++; @(negedge clk); end
    chk(req, n, exp);
  endtask

  function automatic int base(int w, logic [7:0] b);
    if (w == 0) return int'(b);
    if (w == 1) return 256 + int'(b);
    return 512 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] ptrc(int w);
    return (w == 0) ? 8'h00 : (w == 1) ? 8'h01 : 8'h50;
  endfunction
  function automatic int stat_exp(logic f);
    return f ? 8'hC1 : 8'hC0;
  endfunction

  task automatic rd(int w, logic [7:0] b, int row, int n, string req);
    int c;
    cmd(ptrc(w)); win_m = w;
    adr(b); adr(8'(row)); adr(0); adr(0);
    wait_ready(T_READ, "R2");
    c = base(w, b);
    if (win_m == 1) win_m = 0;
    for (int k = 0; k < n; k++) begin
      chk(req, dout, mdl[row*PB + c]);
      rpulse();
      c++;
    end
  endtask

  task automatic prog(int w, logic [7:0] b, int row, int n, logic [7:0] d0,
                      logic [7:0] step, int extra);
    int c; logic f; logic [7:0] d;
    if (w >= 0) begin cmd(ptrc(w)); win_m = w; end
    cmd(8'h80); adr(b); adr(8'(row)); adr(0); adr(0);
    for (int e = 0; e < extra; e++) adr(8'h03);
    c = base(win_m, b); f = 1'b0;
    for (int k = 0; k < n; k++) begin
      d = 8'(int'(d0) + k * int'(step));
      dat(d);
      if (c < PB) begin
        if ((d & ~mdl[row*PB + c]) != 0) f = 1'b1;
        mdl[row*PB + c] = mdl[row*PB + c] & d;
      end
      c++;
    end
    cmd(8'h10);
    wait_ready(T_PROG, "R6");
    fail_m = f;
    if (win_m == 1) win_m = 0;
  endtask

  task automatic erase(int row);
    int blk;
    cmd(8'h60); adr(8'(row)); adr(0); adr(0); cmd(8'hD0);
    wait_ready(T_ERASE, "R9");
    blk = row / PPB;
    for (int i = 0; i < PPB * PB; i++) mdl[blk*PPB*PB + i] = 8'hFF;
    fail_m = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < PAGES*PB; i++) mdl[i] = 8'hFF;
    void'($urandom(32'd2024));
    rst_n = 0; ce_n = 0; cle = 0; ale = 0; we = 0; re = 0; din = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rb", rb, 1);
    chk("R1 io", dout, 0);
    rd(0, 8'd0, 0, 3, "R1 erased");

    // R8 ID sequence and wrap; R11 unsupported byte keeps mode
    cmd(8'h90); adr(8'h00);
    chk("R8", dout, 8'hEC); rpulse();
    chk("R8", dout, 8'h76); rpulse();
    chk("R8", dout, 8'hA5); rpulse();
    chk("R8", dout, 8'hC0); rpulse();
    chk("R8 wrap", dout, 8'hEC); rpulse();
    cmd(8'h33);
    chk("R11", dout, 8'h76);

    // R6 program then R7 status sticks across strobes
    prog(0, 8'd10, 1, 3, 8'h5A, 8'h11, 0);
    cmd(8'h70);
    chk("R7", dout, stat_exp(fail_m)); rpulse();
    chk("R7 sticky", dout, stat_exp(fail_m));
    rd(0, 8'd8, 1, 6, "R6 readback");

    // R3 upper window, then automatic return to lower half
    prog(1, 8'd4, 2, 1, 8'hAA, 8'h00, 0);
    prog(-1, 8'd4, 2, 1, 8'h55, 8'h00, 0);
    rd(0, 8'd4, 2, 1, "R3 lower");
    rd(1, 8'd4, 2, 1, "R3 upper");

    // R5 extra address bytes
    prog(0, 8'd20, 3, 1, 8'h12, 8'h00, 2);
    rd(0, 8'd20, 2, 1, "R5 other row");
    rd(0, 8'd20, 3, 0, "R5");
    adr(8'h05);
    chk("R5 read extra", dout, mdl[3*PB + 20]);

    // R10 end of block on last page, R4 spare window
    rd(2, 8'd3, 1, 13, "R4 spare read");
    chk("R10 end io", dout, 0);
    chk("R10 end rb", rb, 1);
    prog(2, 8'd2, 0, 20, 8'h3C, 8'h01, 0);
    prog(-1, 8'd0, 0, 2, 8'h0F, 8'h00, 0);
    rd(0, 8'd0, 0, 4, "R4 lower untouched");
    rd(2, 8'd0, 0, 15, "R4 spare data");

    // R10 sequential into next page of same block
    rd(1, 8'd250, 2, 22, "R10 tail");
    wait_ready(T_READ, "R10 next load");
    for (int k = 0; k < 4; k++) begin
      chk("R10 next page", dout, mdl[3*PB + k]);
      rpulse();
    end

    // R7 fail flag
    prog(0, 8'd20, 3, 1, 8'hFF, 8'h00, 0);
    chk("R7 fail model", fail_m, 1);
    cmd(8'h70);
    chk("R7 fail", dout, stat_exp(fail_m));

    // R13 commands during busy
    cmd(8'h00); win_m = 0;
    cmd(8'h80); adr(8'd100); adr(8'd0); adr(0); adr(0); dat(8'h0F);
    mdl[100] = mdl[100] & 8'h0F;
    cmd(8'h10);
    fail_m = 1'b0;
    cmd(8'h90);
    cmd(8'h70);
    chk("R13 busy status", dout, 8'h80);
    while (rb == 1'b0) @(negedge clk);
    chk("R13 ready status", dout, stat_exp(fail_m));
    cmd(8'hFF);
    wait_ready(T_RST, "R13 reset busy");
    chk("R13 reset idle", dout, 0);
    win_m = 0;

    // R12 chip enable high
    rd(0, 8'd98, 0, 2, "R12 setup");
    ce_n = 1;
    rpulse();
    cmd(8'h90);
    ce_n = 0;
    chk("R12", dout, 0);

    // random programs and read-backs
    for (int it = 0; it < 30; it++) begin
      int w, row, n, w2, st, n2;
      logic [7:0] b, b2, d0, st8;
      w = int'($urandom % 3); row = int'($urandom % PAGES);
      n = 1 + int'($urandom % 6);
      b = 8'($urandom); d0 = 8'($urandom); st8 = 8'($urandom);
      prog(w, b, row, n, d0, st8, 0);
      cmd(8'h70);
      chk("R7 random", dout, stat_exp(fail_m));
      w2 = int'($urandom % 3); b2 = 8'($urandom);
      st = base(w2, b2);
      n2 = (527 - st < 5) ? 527 - st : 5;
      rd(w2, b2, row, n2, "R2 random");
    end

    // R9 erase block 1
    erase(3);
    rd(0, 8'd20, 3, 1, "R9 erased");
    rd(0, 8'd4, 2, 1, "R9 erased");
    rd(0, 8'd10, 1, 3, "R9 other block");
    cmd(8'h70);
    chk("R9 fail cleared", dout, 8'hC0);

    summary();
    $finish;
  end
endmodule